// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block guards a pair of identical processor cores that run the same program, with the second core (the checker) trailing the first (the master) by a fixed number of clock cycles. Each cycle, the block captures the master's instruction address, data address, write data and write enable, together with a valid flag and a parity bit. It keeps these values in a delay line of `LAG` register stages. When a step leaves the delay line, the checker is presenting its own outputs for that same step. The block compares the two sets of outputs field by field and checks the parity of the stored data bus.

Because of the delay line, the data request reaches shared memory only `LAG` cycles after the master issued it. By then the step has already been compared. A step that fails any check loses its write permission in that same cycle, so the bad write never reaches memory. Detection is recorded in a sticky cause register that software can read. After that, every later write is turned into a read until software clears the register or the block is reset. A two-wire complementary error signal and an interrupt line report the fault to the rest of the system.

The staggered timing means a disturbance that hits both cores at once strikes them at different points in their work. The two cores then show different symptoms, which the comparison can catch.

Top module: `lockstep_out_cmp`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_req is 0, err_rail is 2'b01, irq is 0 and st_status is 0.
- R2: A master step driven in cycle n shows up on mem_req, mem_addr and mem_wdata in cycle n+LAG. With no fault, mem_we in that cycle equals the step's write enable.
- R3: While both valid flags are high in the compare cycle, each field that differs sets its own st_status bit on the next edge: bit 0 instruction address, bit 1 data address, bit 2 write data, bit 3 write enable.
- R4: In the compare cycle of a step that fails any check, mem_we is 0 and mem_req still follows the step, so the access goes out as a read.
- R5: err_rail is 2'b10 while a check fails in the current compare cycle or any st_status bit is set. Otherwise it is 2'b01. It is never 2'b00 or 2'b11.
- R6: While any st_status bit is set, mem_we stays 0 for every step.
- R7: A valid step whose data address, write data and parity bit XOR to 1 (even parity broken) sets st_status bit 4 and is not written.
- R8: When the checker valid flag differs from the valid flag of the step leaving the delay line, st_status bit 5 is set.
- R9: irq is 1 exactly while st_status is nonzero, so it rises on the edge after a failed check.
- R10: A st_clr pulse replaces st_status with the causes found in that same cycle. With no new cause it clears the register, irq and the write block.
- R11: Without st_clr, a st_status bit once set stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_valid | input | 1 | Master issues a step this cycle |
| m_iaddr | input | ADDR_W | Master instruction address |
| m_daddr | input | ADDR_W | Master data address |
| m_wdata | input | DATA_W | Master write data |
| m_we | input | 1 | Master write enable |
| m_par | input | 1 | Even parity bit over m_daddr and m_wdata |
| c_valid | input | 1 | Checker issues a step this cycle |
| c_iaddr | input | ADDR_W | Checker instruction address |
| c_daddr | input | ADDR_W | Checker data address |
| c_wdata | input | DATA_W | Checker write data |
| c_we | input | 1 | Checker write enable |
| st_clr | input | 1 | Software clear of the cause register |
| mem_req | output | 1 | Delayed data request to memory |
| mem_addr | output | ADDR_W | Delayed data address |
| mem_wdata | output | DATA_W | Delayed write data |
| mem_we | output | 1 | Delayed write enable, masked on fault |
| err_rail | output | 2 | Complementary error pair: 01 healthy, 10 fault |
| irq | output | 1 | Interrupt request while a cause is recorded |
| st_status | output | 6 | Sticky cause register |

## Verification
The assertions assume that the checker presents the same step exactly `LAG` cycles after the master. They also assume that st_clr is never raised during reset. Under these assumptions, any divergence seen at the comparator comes from a fault and not from misaligned stimulus.

The bench keeps a history of every master step it drives and replays that history to the checker inputs `LAG` cycles later. The checker copy diverges only where a table entry deliberately flips one field, drops the checker valid flag, or breaks the master parity.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;

    // Outputs of one core for one step
    typedef struct packed {
        logic [ADDR_W-1:0] iaddr;
        logic [ADDR_W-1:0] daddr;
        logic [DATA_W-1:0] wdata;
        logic              we;
    } bus_t;

    // One entry of the master delay line
    typedef struct packed {
        logic valid;
        logic par;
        bus_t bus;
    } slot_t;

    // Cause register layout: iaddr is bit 0, step is bit 5
    typedef struct packed {
        logic step;
        logic parity;
        logic we;
        logic wdata;
        logic daddr;
        logic iaddr;
    } cause_t;

    localparam int CAUSE_W = $bits(cause_t);

    // Even parity over data address, write data and the parity bit
    function automatic logic parity_good(input bus_t b, input logic p);
        return ~(^{b.daddr, b.wdata, p});
    endfunction

endpackage

// File: rtl/lsc_delay_line.sv
module lsc_delay_line
    import lsc_pkg::*;
#(
    parameter int LAG = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t d,
    output slot_t q
);

    slot_t stg [LAG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAG; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < LAG; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[LAG-1];

endmodule

// File: rtl/lsc_compare.sv
module lsc_compare
    import lsc_pkg::*;
(
    input  slot_t  tail,
    input  logic   c_valid,
    input  bus_t   chk,
    output cause_t cause
);

    logic both;

    always_comb begin
        both         = tail.valid & c_valid;
        cause        = '0;
        cause.iaddr  = both & (tail.bus.iaddr != chk.iaddr);
        cause.daddr  = both & (tail.bus.daddr != chk.daddr);
        cause.wdata  = both & (tail.bus.wdata != chk.wdata);
        cause.we     = both & (tail.bus.we    != chk.we);
        cause.parity = tail.valid & ~parity_good(tail.bus, tail.par);
        cause.step   = tail.valid ^ c_valid;
    end

endmodule

// File: rtl/lsc_status.sv
module lsc_status
    import lsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t cause,
    input  logic   clr,
    output cause_t status_q
);

    always_ff @(posedge clk) begin
        if (rst)      status_q <= '0;
        else if (clr) status_q <= cause;
        else          status_q <= status_q | cause;
    end

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((status_q & $past(status_q)) == $past(status_q))); // R11

endmodule

// File: rtl/lockstep_out_cmp.sv
module lockstep_out_cmp
    import lsc_pkg::*;
#(
    parameter int LAG = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               m_valid,
    input  logic [ADDR_W-1:0]  m_iaddr,
    input  logic [ADDR_W-1:0]  m_daddr,
    input  logic [DATA_W-1:0]  m_wdata,
    input  logic               m_we,
    input  logic               m_par,
    input  logic               c_valid,
    input  logic [ADDR_W-1:0]  c_iaddr,
    input  logic [ADDR_W-1:0]  c_daddr,
    input  logic [DATA_W-1:0]  c_wdata,
    input  logic               c_we,
    input  logic               st_clr,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    output logic [1:0]         err_rail,
    output logic               irq,
    output logic [CAUSE_W-1:0] st_status
);

    slot_t  head, tail;
    bus_t   chk;
    cause_t cause, status_q;
    logic   fault;

    assign head = '{valid: m_valid, par: m_par,
                    bus: '{iaddr: m_iaddr, daddr: m_daddr, wdata: m_wdata, we: m_we}};
    assign chk  = '{iaddr: c_iaddr, daddr: c_daddr, wdata: c_wdata, we: c_we};

    lsc_delay_line #(.LAG(LAG)) u_delay (
        .clk (clk),
        .rst (rst),
        .d   (head),
        .q   (tail)
    );

    lsc_compare u_cmp (
        .tail    (tail),
        .c_valid (c_valid),
        .chk     (chk),
        .cause   (cause)
    );

    lsc_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .cause    (cause),
        .clr      (st_clr),
        .status_q (status_q)
    );

    // A fault in the compare cycle or a recorded cause blocks the write
    assign fault     = (|cause) | (|status_q);
    assign mem_req   = tail.valid;
    assign mem_addr  = tail.bus.daddr;
    assign mem_wdata = tail.bus.wdata;
    assign mem_we    = tail.valid & tail.bus.we & ~fault;
    assign err_rail  = fault ? 2'b10 : 2'b01;
    assign irq       = |status_q;
    assign st_status = status_q;

    AST_WRITE_CONFINED: assert property (@(posedge clk) disable iff (rst)
        (|st_status) |-> !mem_we); // R6

    AST_RAIL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        $countones(err_rail) == 1); // R5

    AST_IRQ_AFTER_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (|cause) |=> irq); // R9

    AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req); // R4

    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (st_clr && !(|cause)) |=> !irq); // R10

endmodule

// File: tb/lockstep_out_cmp_tb.sv
module lockstep_out_cmp_tb;
    import lsc_pkg::*;

    localparam int LAG = 2;
    localparam int NV  = 20;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst, m_valid, m_we, m_par, c_valid, c_we, st_clr;
    logic [ADDR_W-1:0]  m_iaddr, m_daddr, c_iaddr, c_daddr, mem_addr;
    logic [DATA_W-1:0]  m_wdata, c_wdata, mem_wdata;
    logic               mem_req, mem_we, irq;
    logic [1:0]         err_rail;
    logic [CAUSE_W-1:0] st_status;

    lockstep_out_cmp #(.LAG(LAG)) u_dut (
        .clk(clk), .rst(rst),
        .m_valid(m_valid), .m_iaddr(m_iaddr), .m_daddr(m_daddr),
        .m_wdata(m_wdata), .m_we(m_we), .m_par(m_par),
        .c_valid(c_valid), .c_iaddr(c_iaddr), .c_daddr(c_daddr),
        .c_wdata(c_wdata), .c_we(c_we), .st_clr(st_clr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .err_rail(err_rail), .irq(irq), .st_status(st_status)
    );

    // code: 0 none, 1 iaddr, 2 daddr, 3 wdata, 4 we flipped at checker, 5 checker valid dropped
    typedef struct packed {
        logic              v;
        logic              we;
        logic              bp;
        logic [2:0]        code;
        logic              clr;
        logic [ADDR_W-1:0] ia;
        logic [ADDR_W-1:0] da;
        logic [DATA_W-1:0] wd;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0010, 16'h0100, 32'hAAAA0001},
        '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0014, 16'h0104, 32'h00000000},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0018, 16'h0108, 32'h12345678},
        '{1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0000, 32'h00000000},
        '{1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 16'h0020, 16'h0200, 32'hDEADBEEF},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0024, 16'h0204, 32'h0F0F0F0F},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 16'h0028, 16'h0208, 32'h11111111},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 16'h002C, 16'h020C, 32'h22222222},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0030, 16'h0210, 32'h33333333},
        '{1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 16'h0034, 16'h0214, 32'h44444444},
        '{1'b1, 1'b1, 1'b0, 3'd5, 1'b0, 16'h0038, 16'h0218, 32'h55555555},
        '{1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 16'h003C, 16'h021C, 32'h66666666},
        '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0040, 16'h0220, 32'h77777777},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 16'h0044, 16'h0224, 32'h88888888},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 16'h0048, 16'h0228, 32'h99999999},
        '{1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 16'h004C, 16'h022C, 32'hAAAAAAAA},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 16'h0050, 16'h0230, 32'hBBBBBBBB},
        '{1'b1, 1'b1, 1'b0, 3'd4, 1'b1, 16'h0054, 16'h0234, 32'hCCCCCCCC},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 16'h0058, 16'h0238, 32'hDDDDDDDD},
        '{1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 16'h005C, 16'h023C, 32'hEEEEEEEE}
    };

    int nchk  = 0;
    int nfail = 0;
    int ncyc  = 0;
    vec_t hist [0:255];
    logic [CAUSE_W-1:0] m_stat = '0;
    string lbl_stat = "R1";

    task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
        nchk++;
        if (a !== e) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", r, a, e);
        end
    endtask

    task automatic idle_inputs();
        m_valid = 0; m_we = 0; m_par = 0; m_iaddr = '0; m_daddr = '0; m_wdata = '0;
        c_valid = 0; c_we = 0; c_iaddr = '0; c_daddr = '0; c_wdata = '0; st_clr = 0;
    endtask

    task automatic run_cycle(input vec_t mv);
        vec_t tv;
        logic [CAUSE_W-1:0] ec;
        logic fault;
        string lw;
        @(negedge clk);
        hist[ncyc] = mv;
        m_valid = mv.v; m_we = mv.we; m_iaddr = mv.ia; m_daddr = mv.da; m_wdata = mv.wd;
        m_par   = (^{mv.da, mv.wd}) ^ mv.bp;
        st_clr  = mv.clr;
        tv = (ncyc >= LAG) ? hist[ncyc-LAG] : '0;
        c_valid = (tv.code == 3'd5) ? ~tv.v : tv.v;
        c_iaddr = tv.ia ^ {{(ADDR_W-1){1'b0}}, tv.code == 3'd1};
        c_daddr = tv.da ^ {{(ADDR_W-1){1'b0}}, tv.code == 3'd2};
        c_wdata = tv.wd ^ {{(DATA_W-1){1'b0}}, tv.code == 3'd3};
        c_we    = tv.we ^ (tv.code == 3'd4);
        ec = '0;
        ec[0] = tv.v && tv.code == 3'd1;
        ec[1] = tv.v && tv.code == 3'd2;
        ec[2] = tv.v && tv.code == 3'd3;
        ec[3] = tv.v && tv.code == 3'd4;
        ec[4] = tv.v && tv.bp;
        ec[5] = tv.code == 3'd5;
        #1;
        fault = (|ec) || (|m_stat);
        chk("R2 mem_req", 64'(mem_req), 64'(tv.v));
        if (tv.v) begin
            chk("R2 mem_addr", 64'(mem_addr), 64'(tv.da));
            chk("R2 mem_wdata", 64'(mem_wdata), 64'(tv.wd));
        end
        lw = (|ec) ? "R4 mem_we" : ((|m_stat) ? "R6 mem_we" : "R2 mem_we");
        chk(lw, 64'(mem_we), 64'(tv.v & tv.we & ~fault));
        chk("R5 err_rail", 64'(err_rail), fault ? 64'd2 : 64'd1);
        chk("R9 irq", 64'(irq), 64'(|m_stat));
        chk({lbl_stat, " st_status"}, 64'(st_status), 64'(m_stat));
        @(posedge clk);
        m_stat = mv.clr ? ec : (m_stat | ec);
        if (mv.clr)     lbl_stat = "R10";
        else if (ec[4]) lbl_stat = "R7";
        else if (ec[5]) lbl_stat = "R8";
        else if (|ec)   lbl_stat = "R3";
        else            lbl_stat = "R11";
        ncyc++;
    endtask

    task automatic check_reset_state();
        chk("R1 mem_req", 64'(mem_req), 64'd0);
        chk("R1 err_rail", 64'(err_rail), 64'd1);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 st_status", 64'(st_status), 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 check_reset_state();                 // R1 during reset
        @(negedge clk) rst = 1'b0;
        #1 check_reset_state();                 // R1 first cycle after reset
        @(posedge clk);

        for (int i = 0; i < NV; i++) run_cycle(TBL[i]);
        for (int i = 0; i < LAG; i++) run_cycle('0);

        // Recorded cause must survive idle cycles, then reset clears it (R1, R11)
        @(negedge clk); idle_inputs(); #1;
        chk("R11 irq held", 64'(irq), 64'(|m_stat));
        chk("R11 st_status held", 64'(st_status), 64'(m_stat));
        rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check_reset_state();

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule